// File: doc/BRIEF.md
# Comma-Detect Word Aligner

This block receives a stream of 10-bit parallel words whose character boundaries can fall at any of ten bit positions relative to the word boundary. It joins two consecutive words into a 20-bit window and looks for the K28.5 comma in either running-disparity form. When it finds the comma, it records that bit offset and from then on delivers one correctly framed 10-bit character per clock.

The search is armed by an asynchronous enable. The enable passes through a synchronizer, and a rising edge of the synchronized level starts a hunt. The first comma found in the hunt fixes the offset and raises the lock output. The offset then stays fixed until the enable is dropped and raised again and a new comma arrives. If the enable drops during a hunt before a comma is seen, the hunt is abandoned and the old offset stays in use.

The controller has three states. `ST_IDLE` means no hunt is active. `ST_HUNT` means a search is armed. `ST_LOCK` means an offset has been captured. The transitions are:
- arm: `ST_IDLE`→`ST_HUNT` and `ST_LOCK`→`ST_HUNT`, on a synchronized rising edge of the enable.
- capture: `ST_HUNT`→`ST_LOCK`, when a comma is found.
- abort: `ST_HUNT`→`ST_IDLE`, when the synchronized enable is low.

Top module: `comma_aligner`

## Requirements
- R1: After reset, `aln_lock` and `aln_valid` are 0 and `aln_word` is 0.
- R2: A comma received while no hunt has been armed is ignored: `aln_lock` and `aln_valid` stay 0.
- R3: The enable acts only after three synchronizer flops. A comma whose first bit is in the word presented on the same clock as the enable's first high sample is not captured.
- R4: The comma is matched in transmission order, where bit 0 of a word is the first bit received. In vector form the two codes are 10'h17C and 10'h283. Either code is matched at any offset 0 to 9. The window is two consecutive words, and the earlier word supplies the low ten bits.
- R5: Let word n be the word that holds the comma's first bit, and let it be captured at clock edge t. After edge t+2, `aln_lock` is 1 and `aln_word` equals the comma. On the first cycle that `aln_lock` is 1, `aln_word` is a comma.
- R6: After the first capture, each clock delivers the next ten stream bits starting at the captured offset. The character that follows the comma appears on the next clock. `aln_valid` stays 1 from then on and is 1 whenever `aln_lock` is 1.
- R7: A new arming clears `aln_lock` until the next comma is found. Dropping the enable while locked does not clear it.
- R8: While locked, a comma at a different offset does not change the alignment.
- R9: If the enable drops during a hunt before any comma arrives, the hunt ends, `aln_lock` stays 0 and the previous offset remains in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_en | input | 1 | Asynchronous search enable; a rising edge arms a hunt |
| rx_word | input | 10 | Unaligned word; bit 0 is the earliest received bit |
| aln_word | output | 10 | Framed character at the captured offset |
| aln_valid | output | 1 | High from the first capture onward |
| aln_lock | output | 1 | High while an offset captured in the latest hunt is in use |

## Verification
The checks on offset uniqueness assume that the incoming bit stream holds a comma at no more than one position within any 20-bit window. Such a pattern arises only where a comma follows the diagnostic K28.7, and the stimulus never sends that pair. The stimulus builds its stream from an alternating filler, a marker character whose longest run is three bits, and the two comma forms. The only five-bit runs in the stream therefore belong to the commas. The enable is held at each level for several clocks, so a single sample of the synchronizer never decides an edge. The expected framed words are taken directly from the stream bits the bench itself emitted.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;

    localparam int unsigned SYM_W = 10;

    // Comma codes, bit 0 = first transmitted bit
    localparam logic [SYM_W-1:0] COMMA_RDN = 10'h17C;
    localparam logic [SYM_W-1:0] COMMA_RDP = 10'h283;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_LOCK
    } aln_state_e;

endpackage

// File: rtl/ca_sync.sv
module ca_sync #(
    parameter int unsigned STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);

    logic [STAGES-1:0] sr_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sr_q   <= (sr_q << 1) | STAGES'(async_in);
            last_q <= sr_q[STAGES-1];
        end
    end

    assign level = sr_q[STAGES-1];
    assign rise  = level & ~last_q;

    // R3: an arming pulse lasts exactly one cycle
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/ca_scan.sv
module ca_scan
    import comma_align_pkg::*;
#(
    parameter int unsigned OFF_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SYM_W-1:0]     word_in,
    output logic [2*SYM_W-1:0]   window,
    output logic                 hit,
    output logic [OFF_W-1:0]     hit_off
);

    logic [SYM_W-1:0] cur_q;
    logic [SYM_W-1:0] prev_q;
    logic [SYM_W-1:0] match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            cur_q  <= word_in;
            prev_q <= cur_q;
        end
    end

    // earlier word holds the low half of the window
    assign window = {cur_q, prev_q};

    for (genvar k = 0; k < SYM_W; k++) begin : g_off
        assign match[k] = (window[k +: SYM_W] == COMMA_RDN) ||
                          (window[k +: SYM_W] == COMMA_RDP);
    end

    // lowest offset takes priority
    always_comb begin
        hit     = |match;
        hit_off = '0;
        for (int k = SYM_W - 1; k >= 0; k--) begin
            if (match[k]) hit_off = OFF_W'(k);
        end
    end

    // R4: a legal stream shows the comma at no more than one offset
    p_single_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/ca_fsm.sv
module ca_fsm
    import comma_align_pkg::*;
#(
    parameter int unsigned OFF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             en_lvl,
    input  logic             hit,
    input  logic [OFF_W-1:0] hit_off,
    output logic             lock,
    output logic             take,
    output logic [OFF_W-1:0] sel_off
);

    aln_state_e       state_q, state_d;
    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    off_q <= '0;
        else if (take) off_q <= hit_off;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (arm) state_d = ST_HUNT;
            ST_HUNT: begin
                if (!en_lvl)  state_d = ST_IDLE;
                else if (hit) state_d = ST_LOCK;
            end
            ST_LOCK: if (arm) state_d = ST_HUNT;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        lock    = (state_q == ST_LOCK);
        take    = (state_q == ST_HUNT) && en_lvl && hit;
        sel_off = take ? hit_off : off_q;
    end

    p_arm_drops_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !lock);

    p_lock_holds_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !arm) |=> (lock && $stable(off_q)));

    p_abort_keeps_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && !en_lvl) |=> (!lock && $stable(off_q)));

endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
    import comma_align_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             align_en,
    input  logic [SYM_W-1:0] rx_word,
    output logic [SYM_W-1:0] aln_word,
    output logic             aln_valid,
    output logic             aln_lock
);

    localparam int unsigned OFF_W = $clog2(SYM_W);

    logic               en_lvl;
    logic               arm;
    logic [2*SYM_W-1:0] window;
    logic               hit;
    logic [OFF_W-1:0]   hit_off;
    logic               take;
    logic [OFF_W-1:0]   sel_off;

    ca_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (align_en),
        .level    (en_lvl),
        .rise     (arm)
    );

    ca_scan #(.OFF_W(OFF_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_in (rx_word),
        .window  (window),
        .hit     (hit),
        .hit_off (hit_off)
    );

    ca_fsm #(.OFF_W(OFF_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .en_lvl  (en_lvl),
        .hit     (hit),
        .hit_off (hit_off),
        .lock    (aln_lock),
        .take    (take),
        .sel_off (sel_off)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aln_word  <= '0;
            aln_valid <= 1'b0;
        end else begin
            if (take)              aln_valid <= 1'b1;
            if (take || aln_valid) aln_word  <= window[sel_off +: SYM_W];
        end
    end

    p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        aln_valid |=> aln_valid);

    p_lock_implies_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        aln_lock |-> aln_valid);

    p_lock_shows_comma_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aln_lock) |-> (aln_word == COMMA_RDN || aln_word == COMMA_RDP));

endmodule

// File: tb/sim_comma_aligner.sv
module sim_comma_aligner;
    import comma_align_pkg::*;

    localparam logic [9:0] FILL = 10'h155;
    localparam logic [9:0] MARK = 10'b0010111001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       align_en = 1'b0;
    logic [9:0] rx_word = '0;
    logic [9:0] aln_word;
    logic       aln_valid;
    logic       aln_lock;

    int   n_chk = 0;
    int   n_bad = 0;
    int   nwords = 0;
    int   pushed = 0;
    logic bitq[$];
    logic sent[$];

    always #5 clk = ~clk;

    comma_aligner u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .align_en  (align_en),
        .rx_word   (rx_word),
        .aln_word  (aln_word),
        .aln_valid (aln_valid),
        .aln_lock  (aln_lock)
    );

    task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push_sym(input logic [9:0] s);
        for (int i = 0; i < 10; i++) begin
            bitq.push_back(s[i]);
            pushed++;
        end
    endtask

    task automatic push_pad(input int n);
        for (int i = 0; i < n; i++) begin
            bitq.push_back((i % 2 == 0) ? 1'b1 : 1'b0);
            pushed++;
        end
    endtask

    // sample point: outputs reflect edges so far; then drive next word
    task automatic tick(input logic e);
        logic [9:0] w;
        @(negedge clk);
        while (bitq.size() < 10) push_sym(FILL);
        for (int i = 0; i < 10; i++) begin
            w[i] = bitq.pop_front();
            sent.push_back(w[i]);
        end
        rx_word  = w;
        align_en = e;
        nwords++;
    endtask

    // framed word expected at the sample taken by the latest tick
    function automatic logic [9:0] model(input int k);
        logic [9:0] r;
        int b;
        b = 10 * (nwords - 4) + k;
        for (int i = 0; i < 10; i++) r[i] = (b + i >= 0) ? sent[b + i] : 1'b0;
        return r;
    endfunction

    task automatic arm(input bit was_locked);
        for (int i = 0; i < 4; i++) tick(1'b0);
        if (was_locked) chk(aln_lock == 1'b1, "R7 enable drop keeps lock", {9'd0, aln_lock}, 10'd1);
        for (int i = 0; i < 6; i++) tick(1'b1);
        chk(aln_lock == 1'b0, "R7 arming clears lock", {9'd0, aln_lock}, 10'd0);
    endtask

    task automatic align_to(input int target, input logic [9:0] c);
        int  cs;
        bit  found;
        push_pad((target - (pushed % 10) + 10) % 10);
        cs = pushed;
        push_sym(c);
        push_sym(MARK);
        found = 0;
        for (int i = 0; i < 14 && !found; i++) begin
            tick(1'b1);
            if (aln_lock) found = 1;
        end
        chk(found, "R5 lock after comma", {9'd0, aln_lock}, 10'd1);
        chk(aln_word == c, "R4 comma framed", aln_word, c);
        chk(nwords - 4 == cs / 10, "R5 capture latency", 10'(nwords - 4), 10'(cs / 10));
        tick(1'b1);
        chk(aln_word == MARK, "R6 next character", aln_word, MARK);
        for (int i = 0; i < 3; i++) begin
            tick(1'b1);
            chk(aln_word == model(target), "R6 stream framing", aln_word, model(target));
        end
        chk(aln_valid == 1'b1, "R6 valid after lock", {9'd0, aln_valid}, 10'd1);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) tick(1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) tick(1'b0);
        chk(aln_lock == 1'b0, "R1 lock after reset", {9'd0, aln_lock}, 10'd0);
        chk(aln_valid == 1'b0, "R1 valid after reset", {9'd0, aln_valid}, 10'd0);
        chk(aln_word == 10'd0, "R1 word after reset", aln_word, 10'd0);
    endtask

    task automatic t_no_arm;
        push_pad((2 - (pushed % 10) + 10) % 10);
        push_sym(COMMA_RDN);
        push_sym(MARK);
        for (int i = 0; i < 12; i++) begin
            tick(1'b0);
            chk(aln_lock == 1'b0 && aln_valid == 1'b0, "R2 unarmed comma ignored",
                {8'd0, aln_lock, aln_valid}, 10'd0);
        end
    endtask

    task automatic t_sync_delay;
        int cs;
        push_pad((6 - (pushed % 10) + 10) % 10);
        cs = pushed;
        push_sym(COMMA_RDP);
        push_sym(MARK);
        while (nwords < cs / 10) tick(1'b0);
        tick(1'b1);
        for (int i = 0; i < 10; i++) tick(1'b1);
        chk(aln_lock == 1'b0, "R3 comma before sync delay missed", {9'd0, aln_lock}, 10'd0);
        align_to(3, COMMA_RDN);
    endtask

    task automatic t_hold_when_locked;
        push_pad(4);
        push_sym(COMMA_RDP);
        push_sym(MARK);
        for (int i = 0; i < 12; i++) begin
            tick(1'b1);
            chk(aln_lock == 1'b1 && aln_word == model(3), "R8 offset held while locked",
                aln_word, model(3));
        end
    endtask

    task automatic t_abort;
        arm(1'b1);
        for (int i = 0; i < 6; i++) tick(1'b0);
        push_pad((5 - (pushed % 10) + 10) % 10);
        push_sym(COMMA_RDN);
        push_sym(MARK);
        for (int i = 0; i < 12; i++) begin
            tick(1'b0);
            chk(aln_lock == 1'b0 && aln_valid == 1'b1 && aln_word == model(9),
                "R9 aborted hunt keeps old offset", aln_word, model(9));
        end
    endtask

    initial begin
        t_reset();
        t_no_arm();
        t_sync_delay();
        t_hold_when_locked();
        arm(1'b1);
        align_to(0, COMMA_RDP);
        arm(1'b1);
        align_to(9, COMMA_RDN);
        t_abort();
        arm(1'b0);
        align_to(5, COMMA_RDP);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule